// File: doc/BRIEF.md
# Multi-Channel Phase-Angle Lamp Dimmer

This block controls a bank of lamp channels by phase-angle firing within each half-cycle of the AC mains. A zero-crossing detector feeds the block one pulse per half-cycle. The block counts core clocks between crossings and divides each half-cycle into 256 equal dimming steps. Every channel holds an 8-bit level. When the running step number equals that level, the channel's active-low triac drive output asserts. The output then holds until the next crossing releases all channels together. The step length follows the mains. It is recomputed at every crossing from the half-cycle that has just ended, and it is applied throughout the half-cycle that follows.

A host loads the levels serially with three wires: a data line, a shift clock and a strobe. The shift chain holds one byte per channel. Shifting alone changes nothing at the outputs. A strobe copies the whole chain into the working latches in one step. All four control inputs are asynchronous to the core clock. The block resynchronises them and acts on their rising edges. A low level has an earlier firing point and therefore gives a brighter lamp.

Top module: `phase_dimmer`

## Requirements
- R1: While reset is applied and right after it is released, every bit of `drive_n` is high (inactive).
- R2: No output goes low until two zero crossings have been detected since reset.
- R3: At each crossing the step length becomes floor(P/256) clocks, with a minimum of 1, where P is the number of clocks between this crossing and the previous one. That length stays fixed until the next crossing.
- R4: Let k be the clock edge at which a rising `zc_in` is first sampled, and let len be the step length from R3. A channel with level L then drives its `drive_n` bit low from edge k+3+L*len.
- R5: All `drive_n` bits are high after edge k+2 of every crossing. Between crossings a low output stays low.
- R6: The step number stops at 255 until the next crossing and never wraps, so no channel fires twice in one half-cycle.
- R7: Each rising edge of `sclk_in` shifts `sdata_in` into the chain. After N_CH*8 shifts, channel 0 holds the last 8 bits and channel N_CH-1 holds the first 8. Within each byte the MSB is shifted first.
- R8: A rising edge of `strobe_in` copies the chain into the level latches. Shifting without a strobe leaves the firing times unchanged.
- R9: Each input passes through two flip-flops. Only a rising edge counts, so an input that stays high triggers only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zc_in | input | 1 | Zero-crossing pulse, asynchronous |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| sdata_in | input | 1 | Serial level data, sampled on shift clock rise |
| strobe_in | input | 1 | Transfers the shift chain into the level latches |
| drive_n | output | N_CH | Active-low triac drive, one bit per channel |

## Verification
A wrong step length or a wrong step count shows at the ports within one half-cycle. Every channel's falling edge then lands on a cycle other than crossing+3+L*len, so each level probes a different point of the step ramp. A bad shift order or a bad latch shows up as channels firing at another channel's time. A missing release or a false crossing shows as a rise on a cycle other than crossing+2. Long half-cycles, mid-cycle shifting and late strobes cover the hold and saturation paths.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned PD_LVL_W      = 8;
  localparam int unsigned PD_STEP_SHIFT = 8;
  typedef logic [PD_LVL_W-1:0] pd_level_t;
  localparam pd_level_t PD_STEP_MAX = '1;
  typedef enum logic [1:0] {PD_WAIT0, PD_WAIT1, PD_RUN} pd_arm_e;
endpackage

// File: rtl/pd_sync_edge.sv
module pd_sync_edge #(
  parameter int unsigned W    = 1,
  parameter bit          EDGE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_in;
      s2_q <= s1_q;
    end
  end

  generate
    if (EDGE) begin : g_edge
      logic [W-1:0] s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s2_q;
      end
      assign q = s2_q & ~s3_q;
    end else begin : g_level
      assign q = s2_q;
    end
  endgenerate
endmodule

// File: rtl/pd_step_timer.sv
module pd_step_timer
  import pd_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_evt,
  output logic             armed,
  output pd_level_t        step,
  output logic [CNT_W-1:0] step_len
);
  logic [CNT_W-1:0] cyc_q, cyc_nxt;
  logic [CNT_W-1:0] len_q, len_nxt;
  logic [CNT_W-1:0] div_q, div_nxt;
  pd_level_t        step_q, step_nxt;
  pd_arm_e          arm_q, arm_nxt;
  logic [CNT_W:0]   period;
  logic [CNT_W-1:0] len_raw;

  assign period  = {1'b0, cyc_q} + (CNT_W+1)'(1);
  assign len_raw = CNT_W'(period >> PD_STEP_SHIFT);

  always_comb begin
    cyc_nxt  = cyc_q;
    len_nxt  = len_q;
    div_nxt  = div_q;
    step_nxt = step_q;
    arm_nxt  = arm_q;
    if (zc_evt) begin
      cyc_nxt  = '0;
      div_nxt  = '0;
      step_nxt = '0;
      len_nxt  = (len_raw == '0) ? CNT_W'(1) : len_raw;
      case (arm_q)
        PD_WAIT0: arm_nxt = PD_WAIT1;
        default:  arm_nxt = PD_RUN;
      endcase
    end else begin
      if (cyc_q != '1) cyc_nxt = cyc_q + CNT_W'(1);
      if (arm_q == PD_RUN) begin
        if (div_q == len_q - CNT_W'(1)) begin
          div_nxt = '0;
          if (step_q != PD_STEP_MAX) step_nxt = step_q + pd_level_t'(1);
        end else begin
          div_nxt = div_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      len_q  <= CNT_W'(1);
      div_q  <= '0;
      step_q <= '0;
      arm_q  <= PD_WAIT0;
    end else begin
      cyc_q  <= cyc_nxt;
      len_q  <= len_nxt;
      div_q  <= div_nxt;
      step_q <= step_nxt;
      arm_q  <= arm_nxt;
    end
  end

  assign armed    = (arm_q == PD_RUN);
  assign step     = step_q;
  assign step_len = len_q;
endmodule

// File: rtl/pd_level_chain.sv
module pd_level_chain
  import pd_pkg::*;
#(
  parameter int unsigned N_CH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift_evt,
  input  logic                     sdata,
  input  logic                     load_evt,
  output logic [N_CH*PD_LVL_W-1:0] levels
);
  localparam int unsigned CHAIN_W = N_CH * PD_LVL_W;

  logic [CHAIN_W-1:0] chain_q, chain_nxt;
  logic [CHAIN_W-1:0] lat_q, lat_nxt;

  always_comb begin
    chain_nxt = chain_q;
    lat_nxt   = lat_q;
    if (shift_evt) chain_nxt = {chain_q[CHAIN_W-2:0], sdata};
    if (load_evt)  lat_nxt   = chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      lat_q   <= '0;
    end else begin
      chain_q <= chain_nxt;
      lat_q   <= lat_nxt;
    end
  end

  assign levels = lat_q;
endmodule

// File: rtl/pd_fire_bank.sv
module pd_fire_bank
  import pd_pkg::*;
#(
  parameter int unsigned N_CH = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     zc_evt,
  input  logic                     armed,
  input  pd_level_t                step,
  input  logic [N_CH*PD_LVL_W-1:0] levels,
  output logic [N_CH-1:0]          drive_n
);
  logic [N_CH-1:0] on_q, on_nxt;

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      pd_level_t lvl;
      logic      hit;
      assign lvl = levels[i*PD_LVL_W +: PD_LVL_W];
      assign hit = armed && (step == lvl);
      always_comb begin
        if (zc_evt) on_nxt[i] = 1'b0;
        else        on_nxt[i] = on_q[i] | hit;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_q <= '0;
    else        on_q <= on_nxt;
  end

  assign drive_n = ~on_q;
endmodule

// File: rtl/phase_dimmer.sv
module phase_dimmer
  import pd_pkg::*;
#(
  parameter int unsigned N_CH  = 128,
  parameter int unsigned CNT_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            zc_in,
  input  logic            sclk_in,
  input  logic            sdata_in,
  input  logic            strobe_in,
  output logic [N_CH-1:0] drive_n
);
  localparam int unsigned EDGE_W = 3;

  logic [1:0]              rs_q;
  logic                    rst_sync_n;
  logic [EDGE_W-1:0]       edge_evt;
  logic                    zc_evt, shift_evt, strobe_evt, sdata_s;
  logic                    armed;
  pd_level_t               step;
  logic [CNT_W-1:0]        step_len;
  logic [N_CH*PD_LVL_W-1:0] levels;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  pd_sync_edge #(.W(EDGE_W), .EDGE(1'b1)) u_edges (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  ({zc_in, sclk_in, strobe_in}),
    .q     (edge_evt)
  );
  assign zc_evt     = edge_evt[2];
  assign shift_evt  = edge_evt[1];
  assign strobe_evt = edge_evt[0];

  pd_sync_edge #(.W(1), .EDGE(1'b0)) u_data (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (sdata_in),
    .q     (sdata_s)
  );

  pd_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .zc_evt   (zc_evt),
    .armed    (armed),
    .step     (step),
    .step_len (step_len)
  );

  pd_level_chain #(.N_CH(N_CH)) u_chain (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .shift_evt (shift_evt),
    .sdata     (sdata_s),
    .load_evt  (strobe_evt),
    .levels    (levels)
  );

  pd_fire_bank #(.N_CH(N_CH)) u_fire (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .zc_evt  (zc_evt),
    .armed   (armed),
    .step    (step),
    .levels  (levels),
    .drive_n (drive_n)
  );
endmodule

// File: rtl/phase_dimmer_chk.sv
module phase_dimmer_chk
  import pd_pkg::*;
#(
  parameter int unsigned N_CH  = 128,
  parameter int unsigned CNT_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     zc_evt,
  input logic                     load_evt,
  input logic                     armed,
  input pd_level_t                step,
  input logic [CNT_W-1:0]         step_len,
  input logic [N_CH*PD_LVL_W-1:0] levels,
  input logic [N_CH-1:0]          drive_n
);
  AST_IDLE_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (&drive_n)); // R2

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    step_len != '0); // R3

  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_evt |=> $stable(step_len)); // R3

  AST_RELEASE_AT_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    zc_evt |=> (&drive_n)); // R5

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_evt |=> ((drive_n & ~$past(drive_n)) == '0)); // R5

  AST_STEP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_evt |=> (step >= $past(step))); // R6

  AST_STEP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (step == PD_STEP_MAX && !zc_evt) |=> (step == PD_STEP_MAX)); // R6

  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(levels)); // R8

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      AST_FIRE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_n[i]) |-> ($past(armed) &&
          $past(step) == $past(levels[i*PD_LVL_W +: PD_LVL_W]))); // R4
    end
  endgenerate
endmodule

bind phase_dimmer phase_dimmer_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .zc_evt   (zc_evt),
  .load_evt (strobe_evt),
  .armed    (armed),
  .step     (step),
  .step_len (step_len),
  .levels   (levels),
  .drive_n  (drive_n)
);

// File: tb/tb_phase_dimmer.sv
module tb_phase_dimmer;
  localparam int N_CH  = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n, zc_in, sclk_in, sdata_in, strobe_in;
  logic [N_CH-1:0] drive_n;

  phase_dimmer #(.N_CH(N_CH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .zc_in(zc_in), .sclk_in(sclk_in),
    .sdata_in(sdata_in), .strobe_in(strobe_in), .drive_n(drive_n)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int ch; int at; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  int lvl_model [N_CH];
  int zc_count = 0;
  int prev_zc = 0;
  int cross_cyc = -100;
  bit done = 1'b0;

  int lv_a [N_CH] = '{0, 1, 5, 17, 100, 200, 254, 255};
  int lv_b [N_CH] = '{255, 128, 3, 64, 64, 9, 0, 250};

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // Driver: issues a crossing and pushes the expected firing items.
  task automatic do_cross();
    int c, p, len;
    c = cyc;
    zc_in = 1'b1;
    zc_count++;
    if (zc_count >= 2) begin
      p = c - prev_zc;
      len = p >> 8;
      if (len == 0) len = 1;
      for (int s = 0; s < 256; s++)
        for (int ch = 0; ch < N_CH; ch++)
          if (lvl_model[ch] == s) exp_q.push_back('{ch: ch, at: c + 4 + s * len});
    end
    prev_zc = c;
    cross_cyc = c + 3;
    repeat (3) @(negedge clk);
    total++;
    if (drive_n !== '1) begin
      bad++;
      $display("FAIL R5: outputs at crossing actual=%b expected=%b", drive_n, {N_CH{1'b1}});
    end
    repeat (4) @(negedge clk);
    zc_in = 1'b0;
  endtask

  task automatic shift_levels(input int lv [N_CH]);
    for (int ch = N_CH - 1; ch >= 0; ch--)
      for (int b = 7; b >= 0; b--) begin
        sdata_in = 1'((lv[ch] >> b) & 1);
        repeat (3) @(negedge clk);
        sclk_in = 1'b1;
        repeat (3) @(negedge clk);
        sclk_in = 1'b0;
      end
  endtask

  task automatic pulse_strobe(input int lv [N_CH]);
    strobe_in = 1'b1;
    repeat (3) @(negedge clk);
    strobe_in = 1'b0;
    repeat (3) @(negedge clk);
    lvl_model = lv;
  endtask

  // Monitor: pops expected items as outputs fall, checks rises.
  logic [N_CH-1:0] prev_dn = '1;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      for (int ch = 0; ch < N_CH; ch++) begin
        if (prev_dn[ch] === 1'b1 && drive_n[ch] === 1'b0) begin
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R2 R4: ch%0d fell at %0d, expected no firing", ch, cyc);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.ch != ch || e.at != cyc) begin
              bad++;
              $display("FAIL R4 R7: actual ch%0d at %0d expected ch%0d at %0d", ch, cyc, e.ch, e.at);
            end
          end
        end
        if (prev_dn[ch] === 1'b0 && drive_n[ch] === 1'b1 && cyc != cross_cyc) begin
          total++;
          bad++;
          $display("FAIL R5 R6 R9: ch%0d rose at %0d expected at %0d", ch, cyc, cross_cyc);
        end
      end
    end
    prev_dn = drive_n;
  end

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; zc_in = 1'b0; sclk_in = 1'b0; sdata_in = 1'b0; strobe_in = 1'b0;
    for (int ch = 0; ch < N_CH; ch++) lvl_model[ch] = 0;
    repeat (3) @(negedge clk);
    total++;
    if (drive_n !== '1) begin
      bad++;
      $display("FAIL R1: in reset actual=%b expected=%b", drive_n, {N_CH{1'b1}});
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    total++;
    if (drive_n !== '1) begin
      bad++;
      $display("FAIL R1: after reset actual=%b expected=%b", drive_n, {N_CH{1'b1}});
    end
    fork
      begin
        // Crossings: 1024, 1024, 3072, 3200, 3200 clock half-cycles.
        wait_cyc(1000);  do_cross();   // first crossing: not armed (R2)
        wait_cyc(2024);  do_cross();   // len 4 (R3)
        wait_cyc(3048);  do_cross();   // len 4, long half-cycle follows (R6)
        wait_cyc(6120);  do_cross();   // len 12 (R3)
        wait_cyc(9320);  do_cross();
        wait_cyc(12520); do_cross();
        wait_cyc(15800);
      end
      begin
        wait_cyc(20);
        shift_levels(lv_a);            // R7
        pulse_strobe(lv_a);            // R8
        wait_cyc(2074);
        shift_levels(lv_b);            // R8: no strobe, timing keeps A levels
        wait_cyc(4148);
        pulse_strobe(lv_b);            // R8: lands after all fired, outputs hold (R5)
      end
    join
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4: missing firings actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule